// File: doc/BRIEF.md
# Reset Cause Status Register

This block is a one-byte, read-only status register. It tells software which on-chip source caused the most recent internal reset. Three single-cycle request pulses come in from the watchdog, the clock monitor and the low-voltage detector. Each pulse sets its own flag. A flag keeps its value through internal resets from the other sources.

The register has its own reset domain. Only the external reset pin or the power-on-clear reset wipes it. Both of these are synchronous and active high. The chip-wide internal reset that the three sources drive never reaches this register.

Software reads the byte through a simple read port made of an address, a read strobe and 8-bit read data. A read returns the current flags in the same cycle. The flags are then cleared on the clock edge that ends the read. Early boot code can therefore read the cause once and find a clean register after that.

Top module: `rstcause_reg`

## Requirements
- R1: When `ext_rst` is high at a rising clock edge, all flags are 00h after that edge, even if a set request arrives in the same cycle.
- R2: When `por_rst` is high at a rising clock edge, all flags are 00h after that edge.
- R3: A `wdog_evt` pulse sets the watchdog flag, which reads back at bit 4, and leaves the other two flags unchanged.
- R4: A `clkmon_evt` pulse sets the clock-monitor flag, which reads back at bit 1, and leaves the other two flags unchanged.
- R5: A `lowv_evt` pulse sets the low-voltage flag, which reads back at bit 0, and leaves the other two flags unchanged.
- R6: A read is `rd_en` high with `rd_addr` equal to FFACh. During that cycle, `rd_data` shows the flags as they were before the read. On the edge that ends the read, every flag clears to 0.
- R7: Bits 7, 6, 5, 3 and 2 of `rd_data` always read 0. Whenever no read is being made, `rd_data` is 00h.
- R8: An access to any other address, or `rd_en` low with the matching address, leaves all flags unchanged.
- R9: If a set request and a clearing read fall in the same cycle, the requested flag is 1 after the edge. The read still clears the flags that had no request.
- R10: Several set requests in the same cycle set all of the matching flags together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| ext_rst | input | 1 | External reset pin, synchronous, active high; clears the register |
| por_rst | input | 1 | Power-on-clear reset, synchronous, active high; clears the register |
| wdog_evt | input | 1 | Watchdog reset request pulse |
| clkmon_evt | input | 1 | Clock-monitor reset request pulse |
| lowv_evt | input | 1 | Low-voltage reset request pulse |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 16 | Read address |
| rd_data | output | 8 | Read data; 00h when no read is being made |

## Verification
`rd_data` is combinational, so a read's value is due in the same cycle as the strobe. Any change to the flags from a set, a clear or a reset shows up only after the next rising edge. The bench drives its inputs on the falling edge and samples `rd_data` 5 ns before the following rising edge. A flag change caused in one step is therefore checked through the read made in the next step. The "unchanged" cases work the same way: the flags are read back in the step right after the stimulus, through the normal read port.

// File: rtl/rstcause_pkg.sv
`timescale 1ns/1ps
package rstcause_pkg;
    localparam int NUM_SRC = 3;
    localparam int DATA_W  = 8;

    // Index of each source in the flag vector
    typedef enum int {
        SRC_WDOG   = 0,
        SRC_CLKMON = 1,
        SRC_LOWV   = 2
    } src_e;

    // Bit position of each flag in the read byte, indexed by src_e
    localparam int SRC_BIT [NUM_SRC] = '{4, 1, 0};

    typedef struct packed {
        logic lowv;
        logic clkmon;
        logic wdog;
    } cause_t;

    // Place the flag vector at its byte positions; all other bits are 0
    function automatic logic [DATA_W-1:0] pack_byte(input logic [NUM_SRC-1:0] f);
        logic [DATA_W-1:0] b;
        b = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            b[SRC_BIT[i]] = f[i];
        end
        return b;
    endfunction
endpackage

// File: rtl/rstcause_decode.sv
`timescale 1ns/1ps
module rstcause_decode #(
    parameter int              ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] REG_ADDR = 16'hFFAC
) (
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              hit
);
    always_comb begin
        hit = rd_en && (rd_addr == REG_ADDR);
    end
endmodule

// File: rtl/rstcause_flags.sv
`timescale 1ns/1ps
module rstcause_flags #(
    parameter int NUM_SRC = 3
) (
    input  logic               clk,
    input  logic               dom_rst,
    input  logic [NUM_SRC-1:0] set_req,
    input  logic               rd_clr,
    output logic [NUM_SRC-1:0] flag_q
);
    // One cell per flag. Priority: domain reset, then set, then read-clear.
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_flag
        always_ff @(posedge clk) begin
            if (dom_rst) begin
                flag_q[g] <= 1'b0;
            end else if (set_req[g]) begin
                flag_q[g] <= 1'b1;
            end else if (rd_clr) begin
                flag_q[g] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/rstcause_rdmux.sv
`timescale 1ns/1ps
module rstcause_rdmux
    import rstcause_pkg::*;
#(
    parameter int N_SRC  = NUM_SRC,
    parameter int BYTE_W = DATA_W
) (
    input  logic              hit,
    input  logic [N_SRC-1:0]  flag_q,
    output logic [BYTE_W-1:0] rd_data
);
    always_comb begin
        rd_data = hit ? pack_byte(flag_q) : '0;
    end
endmodule

// File: rtl/rstcause_reg.sv
`timescale 1ns/1ps
module rstcause_reg
    import rstcause_pkg::*;
#(
    parameter int                ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] REG_ADDR = 16'hFFAC
) (
    input  logic              clk,
    input  logic              ext_rst,
    input  logic              por_rst,
    input  logic              wdog_evt,
    input  logic              clkmon_evt,
    input  logic              lowv_evt,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    // Own reset domain: only the external pin and power-on-clear
    logic               dom_rst;
    logic               hit;
    cause_t             req;
    logic [NUM_SRC-1:0] set_vec;
    logic [NUM_SRC-1:0] flag_q;

    always_comb begin
        dom_rst    = ext_rst | por_rst;
        req.wdog   = wdog_evt;
        req.clkmon = clkmon_evt;
        req.lowv   = lowv_evt;
        set_vec    = req;
    end

    rstcause_decode #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_dec (
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .hit     (hit)
    );

    rstcause_flags #(.NUM_SRC(NUM_SRC)) u_flags (
        .clk     (clk),
        .dom_rst (dom_rst),
        .set_req (set_vec),
        .rd_clr  (hit),
        .flag_q  (flag_q)
    );

    rstcause_rdmux #(.N_SRC(NUM_SRC), .BYTE_W(DATA_W)) u_mux (
        .hit     (hit),
        .flag_q  (flag_q),
        .rd_data (rd_data)
    );
endmodule

// File: rtl/rstcause_chk.sv
`timescale 1ns/1ps
module rstcause_chk
    import rstcause_pkg::*;
#(
    parameter int                ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] REG_ADDR = 16'hFFAC
) (
    input logic               clk,
    input logic               ext_rst,
    input logic               por_rst,
    input logic               wdog_evt,
    input logic               clkmon_evt,
    input logic               lowv_evt,
    input logic               rd_en,
    input logic [ADDR_W-1:0]  rd_addr,
    input logic [DATA_W-1:0]  rd_data,
    input logic [NUM_SRC-1:0] flag_q
);
    logic rst_any;
    logic rd_hit;
    logic any_set;
    assign rst_any = ext_rst | por_rst;
    assign rd_hit  = rd_en && (rd_addr == REG_ADDR);
    assign any_set = wdog_evt | clkmon_evt | lowv_evt;

    p_ext_clear_r1: assert property (@(posedge clk) disable iff (por_rst)
        ext_rst |=> flag_q == '0);

    p_poc_clear_r2: assert property (@(posedge clk) disable iff (ext_rst)
        por_rst |=> flag_q == '0);

    p_wdog_set_r3: assert property (@(posedge clk) disable iff (rst_any)
        wdog_evt |=> flag_q[SRC_WDOG]);

    p_wdog_hold_r3: assert property (@(posedge clk) disable iff (rst_any)
        (wdog_evt && !clkmon_evt && !lowv_evt && !rd_hit)
        |=> (flag_q[SRC_CLKMON] == $past(flag_q[SRC_CLKMON]))
            && (flag_q[SRC_LOWV] == $past(flag_q[SRC_LOWV])));

    p_clkmon_set_r4: assert property (@(posedge clk) disable iff (rst_any)
        clkmon_evt |=> flag_q[SRC_CLKMON]);

    p_lowv_set_r5: assert property (@(posedge clk) disable iff (rst_any)
        lowv_evt |=> flag_q[SRC_LOWV]);

    p_rd_clear_r6: assert property (@(posedge clk) disable iff (rst_any)
        (rd_hit && !any_set) |=> flag_q == '0);

    p_spare_zero_r7: assert property (@(posedge clk) disable iff (rst_any)
        (rd_data[7:5] == 3'b000) && (rd_data[3:2] == 2'b00));

    p_idle_zero_r7: assert property (@(posedge clk) disable iff (rst_any)
        !rd_hit |-> rd_data == '0);

    p_nohit_hold_r8: assert property (@(posedge clk) disable iff (rst_any)
        (!rd_hit && !any_set) |=> $stable(flag_q));

    p_set_wins_r9: assert property (@(posedge clk) disable iff (rst_any)
        (rd_hit && clkmon_evt) |=> flag_q[SRC_CLKMON]);

    p_multi_set_r10: assert property (@(posedge clk) disable iff (rst_any)
        (wdog_evt && clkmon_evt && lowv_evt) |=> flag_q == '1);
endmodule

bind rstcause_reg rstcause_chk #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_chk (
    .clk        (clk),
    .ext_rst    (ext_rst),
    .por_rst    (por_rst),
    .wdog_evt   (wdog_evt),
    .clkmon_evt (clkmon_evt),
    .lowv_evt   (lowv_evt),
    .rd_en      (rd_en),
    .rd_addr    (rd_addr),
    .rd_data    (rd_data),
    .flag_q     (flag_q)
);

// File: tb/sim_rstcause_reg.sv
`timescale 1ns/1ps
module sim_rstcause_reg;
    logic        clk = 1'b0;
    logic        ext_rst, por_rst, wdog_evt, clkmon_evt, lowv_evt, rd_en;
    logic [15:0] rd_addr;
    logic [7:0]  rd_data;
    int          n_cmp = 0;
    int          n_bad = 0;
    bit          finished = 0;

    always #10 clk = ~clk;  // 50 MHz

    rstcause_reg u0 (
        .clk(clk), .ext_rst(ext_rst), .por_rst(por_rst),
        .wdog_evt(wdog_evt), .clkmon_evt(clkmon_evt), .lowv_evt(lowv_evt),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    // Row: {req[3:0], ext, por, wdog, clkmon, lowv, rd, addr[15:0], expected rd_data[7:0]}
    // rd_data is checked before the edge; flags change only after the edge.
    localparam int NV = 20;
    localparam logic [33:0] VEC [NV] = '{
        {4'd1,  6'b100000, 16'h0000, 8'h00}, // R1 pin reset, state 00
        {4'd7,  6'b001000, 16'h0000, 8'h00}, // R7 no read -> 00; wdog set
        {4'd3,  6'b000001, 16'hFFAC, 8'h10}, // R3 watchdog at bit 4
        {4'd6,  6'b000001, 16'hFFAC, 8'h00}, // R6 cleared by previous read
        {4'd4,  6'b000100, 16'h0000, 8'h00}, // R4 clkmon set
        {4'd5,  6'b000010, 16'h0000, 8'h00}, // R5 lowv set
        {4'd8,  6'b000001, 16'hFFAD, 8'h00}, // R8 other address
        {4'd5,  6'b000001, 16'hFFAC, 8'h03}, // R5 lowv plus held clkmon
        {4'd10, 6'b001110, 16'h0000, 8'h00}, // R10 all three together
        {4'd10, 6'b000001, 16'hFFAC, 8'h13}, // R10 all flags set
        {4'd3,  6'b001000, 16'h0000, 8'h00}, // R3 wdog set
        {4'd9,  6'b000101, 16'hFFAC, 8'h10}, // R9 read + clkmon set
        {4'd9,  6'b000001, 16'hFFAC, 8'h02}, // R9 set won, wdog cleared
        {4'd5,  6'b000010, 16'h0000, 8'h00}, // R5 lowv set
        {4'd3,  6'b001000, 16'h0000, 8'h00}, // R3 wdog set, lowv held
        {4'd2,  6'b010000, 16'h0000, 8'h00}, // R2 power-on-clear
        {4'd2,  6'b000001, 16'hFFAC, 8'h00}, // R2 register empty
        {4'd4,  6'b000100, 16'h0000, 8'h00}, // R4 clkmon set
        {4'd3,  6'b001000, 16'h0000, 8'h00}, // R3 wdog set, clkmon held
        {4'd4,  6'b000001, 16'hFFAC, 8'h12}  // R4 clkmon held through wdog
    };

    task automatic step(input logic e, p, w, c, l, r, input logic [15:0] a,
                        input logic [7:0] exp, input string req);
        @(negedge clk);
        ext_rst = e; por_rst = p; wdog_evt = w; clkmon_evt = c;
        lowv_evt = l; rd_en = r; rd_addr = a;
        #5;
        n_cmp++;
        if (rd_data !== exp) begin
            n_bad++;
            $display("FAIL %s: rd_data=%02h expected=%02h", req, rd_data, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        end
    endtask

    initial begin
        ext_rst = 1'b1; por_rst = 1'b1; wdog_evt = 1'b0; clkmon_evt = 1'b0;
        lowv_evt = 1'b0; rd_en = 1'b0; rd_addr = '0;
        repeat (2) @(posedge clk);
        for (int i = 0; i < NV; i++) begin
            step(VEC[i][29], VEC[i][28], VEC[i][27], VEC[i][26], VEC[i][25],
                 VEC[i][24], VEC[i][23:8], VEC[i][7:0], $sformatf("R%0d", VEC[i][33:30]));
        end
        // R1: pin reset beats a simultaneous watchdog request
        step(1, 0, 1, 0, 0, 0, 16'h0000, 8'h00, "R1");
        step(0, 0, 0, 0, 0, 1, 16'hFFAC, 8'h00, "R1");
        // R7 / R8: matching address without strobe reads 00 and does not clear
        step(0, 0, 0, 1, 0, 0, 16'h0000, 8'h00, "R4");
        step(0, 0, 0, 0, 0, 0, 16'hFFAC, 8'h00, "R7");
        step(0, 0, 0, 0, 0, 1, 16'hFFAC, 8'h02, "R8");
        // R2: power-on-clear wipes a set low-voltage flag
        step(0, 0, 0, 0, 1, 0, 16'h0000, 8'h00, "R5");
        step(0, 1, 0, 0, 0, 0, 16'h0000, 8'h00, "R2");
        step(0, 0, 0, 0, 0, 1, 16'hFFAC, 8'h00, "R2");
        // R6: read with a watchdog set in the same cycle keeps only bit 4
        step(0, 0, 1, 0, 1, 0, 16'h0000, 8'h00, "R10");
        step(0, 0, 1, 0, 0, 1, 16'hFFAC, 8'h11, "R6");
        step(0, 0, 0, 0, 0, 1, 16'hFFAC, 8'h10, "R9");
        step(0, 0, 0, 0, 0, 0, 16'h0000, 8'h00, "R7");
        summary();
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not end, actual=hung expected=done");
        summary();
        $finish;
    end
endmodule